// File: doc/BRIEF.md
# Asymmetric Fault Queue Filter

This block filters the one-bit result of a temperature limit comparator before it reaches the status and alarm logic. Each time a conversion completes, a strobe arrives together with a flag saying whether the reading lay outside its limits. The block raises its fault output only once a run of consecutive out-of-limit readings has been seen. The length of that run is a parameter and defaults to three. Any single in-limit reading drops the fault at once. An in-limit reading during the build-up also restarts the run from zero. Short excursions therefore never reach the interrupt status or the alarm pin, while recovery is reported without delay.

The fault output is a level. It is also presented as an active-low alarm pin level. A single-cycle status-set pulse marks each entry into the fault state, for use by an interrupt status register. Cycles without a strobe change nothing: the run counter moves only on conversion strobes. It saturates at the run length while faults continue, so it never wraps.

Top module: `fault_entry_filter`

## Requirements
- R1: While reset is held and in the first cycle after it, fault_o is 0, alarm_n_o is 1 and status_set_o is 0.
- R2: fault_o becomes 1 in the cycle after the clock edge that samples the RUN_LEN-th consecutive strobe with out_limit_i=1 (RUN_LEN defaults to 3). It stays 0 after fewer such strobes.
- R3: When fault_o is 1, one strobe with out_limit_i=0 makes fault_o 0 in the following cycle.
- R4: A strobe with out_limit_i=0 during the build-up restarts the run, so RUN_LEN further consecutive out-of-limit strobes are needed before fault_o rises.
- R5: In a cycle with conv_done_i=0, out_limit_i is ignored. Neither the run count nor fault_o changes, and a run resumes where it stood at the next strobe.
- R6: Out-of-limit strobes that continue past RUN_LEN keep fault_o at 1 without wrapping, however many arrive.
- R7: status_set_o is 1 for exactly one cycle, the cycle in which fault_o first becomes 1. It is 0 at all other times, including during continued faults.
- R8: alarm_n_o is always the inverse of fault_o (0 means alarm).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_done_i | input | 1 | Conversion-complete strobe, one cycle per reading |
| out_limit_i | input | 1 | Comparator result for this reading, 1 = outside limits |
| fault_o | output | 1 | Filtered fault level |
| alarm_n_o | output | 1 | Alarm pin level, active low |
| status_set_o | output | 1 | One-cycle pulse on entry into fault |

## Verification
A single in-limit strobe does two things in the same cycle: it clears an active fault and it restarts the run count. If either effect were missed, the next run would be judged against stale state. The bench provokes this with back-to-back strobes, placing an in-limit reading straight after a fault or after a partial run and then sending out-of-limit readings on every following cycle. It counts that exactly RUN_LEN more readings, and no fewer, raise fault_o and status_set_o again. Random mixtures of strobe and out-of-limit patterns are compared cycle by cycle against a reference model in the bench.

// File: rtl/fq_pkg.sv
package fq_pkg;
   // bits needed to hold a count from 0 up to and including n
   function automatic int unsigned count_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/fq_run_counter.sv
module fq_run_counter #(
   parameter int unsigned RUN_LEN = 3,
   parameter int unsigned CNT_W   = fq_pkg::count_bits(RUN_LEN)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bad_step,    // strobe with out-of-limit reading
   input  logic good_step,   // strobe with in-limit reading
   output logic full_next    // this step completes the run
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(RUN_LEN);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

   logic [CNT_W-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (good_step) begin
         run_q <= '0;
      end else if (bad_step && (run_q != FULL)) begin
         run_q <= run_q + 1'b1;
      end
   end

   assign full_next = bad_step && (run_q >= LAST);
endmodule

// File: rtl/fq_fault_reg.sv
module fq_fault_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_req,
   output logic fault_q,
   output logic enter_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q <= 1'b0;
         enter_q <= 1'b0;
      end else begin
         enter_q <= set_req && !fault_q;
         if (clr_req)      fault_q <= 1'b0;
         else if (set_req) fault_q <= 1'b1;
      end
   end
endmodule

// File: rtl/fault_entry_filter.sv
module fault_entry_filter #(
   parameter int unsigned RUN_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic conv_done_i,
   input  logic out_limit_i,
   output logic fault_o,
   output logic alarm_n_o,
   output logic status_set_o
);
   if (RUN_LEN < 1) begin : g_bad_len
      $error("fault_entry_filter: RUN_LEN must be at least 1");
   end
   if (RUN_LEN > 1024) begin : g_huge_len
      $error("fault_entry_filter: RUN_LEN above 1024 is not supported");
   end

   logic bad_step, good_step, set_req;

   assign bad_step  = conv_done_i && out_limit_i;
   assign good_step = conv_done_i && !out_limit_i;

   if (RUN_LEN == 1) begin : g_direct
      assign set_req = bad_step;
   end else begin : g_counted
      fq_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
         .clk       (clk),
         .rst_n     (rst_n),
         .bad_step  (bad_step),
         .good_step (good_step),
         .full_next (set_req)
      );
   end

   fq_fault_reg u_flt (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (set_req),
      .clr_req (good_step),
      .fault_q (fault_o),
      .enter_q (status_set_o)
   );

   assign alarm_n_o = !fault_o;
endmodule

// File: rtl/fq_checker.sv
module fq_checker #(
   parameter int unsigned RUN_LEN = 3
) (
   input logic clk,
   input logic rst_n,
   input logic conv_done_i,
   input logic out_limit_i,
   input logic fault_o,
   input logic alarm_n_o,
   input logic status_set_o
);
   localparam int unsigned CW = fq_pkg::count_bits(RUN_LEN);
   localparam logic [CW-1:0] FULL = CW'(RUN_LEN);

   logic [CW-1:0] seen_q;   // independent count of consecutive bad readings

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= '0;
      else if (conv_done_i && !out_limit_i) seen_q <= '0;
      else if (conv_done_i && out_limit_i && seen_q != FULL) seen_q <= seen_q + 1'b1;
   end

   always @(posedge clk) begin
      if (!rst_n) assert_reset_quiet_R1: assert (!fault_o && alarm_n_o && !status_set_o);
   end

   assert_entry_on_bad_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_o) |-> $past(conv_done_i && out_limit_i));

   assert_exit_one_good_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done_i && !out_limit_i) |=> !fault_o);

   assert_run_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o == (seen_q == FULL));

   assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_done_i |=> $stable(fault_o));

   assert_held_on_bad_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_o && conv_done_i && out_limit_i) |=> fault_o);

   assert_pulse_on_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      status_set_o |-> (fault_o && !$past(fault_o)));

   assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      status_set_o |=> !status_set_o);
endmodule

bind fault_entry_filter fq_checker #(.RUN_LEN(RUN_LEN)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .conv_done_i  (conv_done_i),
   .out_limit_i  (out_limit_i),
   .fault_o      (fault_o),
   .alarm_n_o    (alarm_n_o),
   .status_set_o (status_set_o)
);

// File: tb/sim_fault_entry_filter.sv
module sim_fault_entry_filter;
   localparam int unsigned N = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic conv_done_i = 1'b0;
   logic out_limit_i = 1'b0;
   logic fault_o, alarm_n_o, status_set_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   int unsigned m_cnt = 0;
   bit m_fault = 1'b0;
   bit m_pulse = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   fault_entry_filter #(.RUN_LEN(N)) u0 (
      .clk(clk), .rst_n(rst_n), .conv_done_i(conv_done_i), .out_limit_i(out_limit_i),
      .fault_o(fault_o), .alarm_n_o(alarm_n_o), .status_set_o(status_set_o)
   );

   task automatic check(input string req, input string what, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   // reference model: next state from the requirements
   function automatic void model_step(input bit s, input bit o);
      m_pulse = 1'b0;
      if (s && o) begin
         if (m_cnt < N) m_cnt++;
         m_pulse = !m_fault && (m_cnt >= N);
         m_fault = (m_cnt >= N);
      end else if (s) begin
         m_cnt = 0;
         m_fault = 1'b0;
      end
   endfunction

   // called at a falling edge: drive, pass one rising edge, compare at the next falling edge
   task automatic cyc(input bit s, input bit o, input string req);
      conv_done_i = s;
      out_limit_i = o;
      model_step(s, o);
      @(posedge clk);
      @(negedge clk);
      check(req, "fault_o", fault_o, m_fault);
      check("R7", "status_set_o", status_set_o, m_pulse);
      check("R8", "alarm_n_o", alarm_n_o, !m_fault);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual expired expected done");
      finish_run();
   end

   initial begin
      int unsigned seed_v;
      seed_v = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      check("R1", "fault_o in reset", fault_o, 1'b0);
      check("R1", "alarm_n_o in reset", alarm_n_o, 1'b1);
      check("R1", "status_set_o in reset", status_set_o, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "fault_o after reset", fault_o, 1'b0);
      check("R1", "status_set_o after reset", status_set_o, 1'b0);

      // R2: two bad readings do not trip, the third does
      cyc(1, 1, "R2"); cyc(1, 1, "R2"); cyc(1, 1, "R2");
      // R6: long run keeps the fault, no wrap
      for (int i = 0; i < 20; i++) cyc(1, 1, "R6");
      // R5: idle cycles with bad flag leave the fault alone
      for (int i = 0; i < 4; i++) cyc(0, i[0], "R5");
      // R3: one good reading clears, then back-to-back rebuild needs a full run
      cyc(1, 0, "R3");
      cyc(1, 1, "R3"); cyc(1, 1, "R3"); cyc(1, 1, "R3");
      cyc(1, 0, "R3");
      // R4: a good reading mid-run restarts the count
      cyc(1, 1, "R4"); cyc(1, 1, "R4"); cyc(1, 0, "R4");
      cyc(1, 1, "R4"); cyc(1, 1, "R4"); cyc(1, 1, "R4");
      cyc(1, 0, "R4");
      // R5: a run pauses across idle cycles and resumes
      cyc(1, 1, "R5"); cyc(1, 1, "R5");
      for (int i = 0; i < 5; i++) cyc(0, 1, "R5");
      cyc(0, 0, "R5");
      cyc(1, 1, "R5");
      cyc(1, 0, "R5");
      // constrained random mixture
      for (int i = 0; i < 4000; i++) begin
         bit s, o;
         s = ($urandom % 4) != 0;
         o = ($urandom % 5) != 0;
         cyc(s, o, "R2");
      end
      finish_run();
   end
endmodule